// File: doc/BRIEF.md
# Vector Narrowing Add/Subtract High-Half Unit

This unit carries out the narrowing "combine wide elements, keep the upper half" vector operations. Two 128-bit source vectors hold wide elements of 16, 32 or 64 bits. For each element position the unit adds or subtracts the pair. It can then add a rounding constant of half a narrow unit. It keeps the upper half of the wide result. The narrow results, each half as wide as a source element, fill 64 bits. Those 64 bits are written into either the low or the high half of a 128-bit destination.

When the low half is written, the upper 64 bits of the destination are cleared. When the high half is written, the old low 64 bits are carried through. A reserved element-size code raises an illegal-encoding flag and returns the old destination untouched. The datapath is combinational and its result is captured in one register stage. A valid strobe on the input produces a valid strobe on the output one cycle later.

Top module: `nh_unit`

## Requirements
- R1: With subtract and round both low, each narrow lane equals bits [2N-1:N] of (wide A + wide B) mod 2^(2N), where N is the narrow width.
- R2: With subtract high, each narrow lane equals the upper half of (wide A − wide B) mod 2^(2N).
- R3: With round high, 2^(N−1) is added to the wrapped sum or difference before the upper half is taken, and the addition wraps mod 2^(2N) without saturation.
- R4: Size code 0 narrows 16-bit lanes to 8 bits, code 1 narrows 32 to 16, and code 2 narrows 64 to 32. Narrow lane i comes from wide lane i (source bits [i*2N +: 2N]) and is placed at bits [i*N +: N] of the 64-bit packed value.
- R5: With the upper-half select low, the packed value goes into result[63:0] and result[127:64] is zero.
- R6: With the upper-half select high, the packed value goes into result[127:64] and result[63:0] equals the old destination's bits [63:0].
- R7: Size code 3 sets the illegal flag to 1 and makes the result equal the full old destination value. Codes 0 to 2 set the illegal flag to 0.
- R8: The result, the illegal flag and the output valid strobe update on the clock edge that samples input valid high. The output valid strobe is high for exactly the cycle after each accepted operation. The result and the illegal flag hold their values while input valid is low.
- R9: While reset is asserted (active low), the output valid strobe, the result and the illegal flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation strobe; operands are sampled on this edge |
| srcA | input | 128 | First source vector of wide elements |
| srcB | input | 128 | Second source vector of wide elements |
| dstOld | input | 128 | Previous destination value |
| sizeCode | input | 2 | Element size: 0, 1 or 2 legal, 3 reserved |
| doSub | input | 1 | 1 = subtract B from A, 0 = add |
| doRound | input | 1 | 1 = add rounding constant before narrowing |
| upperHalf | input | 1 | 1 = write the high half and keep the low half |
| outValid | output | 1 | Result valid, one cycle after inValid |
| result | output | 128 | New destination value |
| illegal | output | 1 | Reserved size code was used |

## Verification
The assertions check on every cycle the half-placement rules: the cleared upper half, the preserved low half, and the whole-vector pass-through for the reserved code. They also check the one-cycle valid timing, the correspondence between the illegal flag and the size code, and that results hold between operations. The per-lane arithmetic cannot be shown by a property. This covers wrapping of sums and differences, rounding carries into the upper half, and lane ordering for each size. Only the bench's sweeps show these, comparing every size, subtract, round and half-select setting against an arithmetic model. The operand patterns are chosen to sit on and beside the rounding carry boundary.

// File: rtl/nh_pkg.sv
package nh_pkg;

  localparam int VEC_W     = 128;
  localparam int HALF_W    = VEC_W / 2;
  localparam int NUM_SIZES = 3;
  localparam int BASE_NW   = 8;

  typedef struct packed {
    logic [NUM_SIZES-1:0] sizeSel;
    logic                 sub;
    logic                 rnd;
    logic                 upper;
    logic                 illegal;
    logic                 load;
  } nhCtrl_t;

endpackage

// File: rtl/nh_ctrl.sv
module nh_ctrl
  import nh_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] sizeCode,
  input  logic       doSub,
  input  logic       doRound,
  input  logic       upperHalf,
  output nhCtrl_t    ctrl
);

  always_comb begin
    ctrl = '0;
    for (int s = 0; s < NUM_SIZES; s++) begin
      ctrl.sizeSel[s] = (sizeCode == 2'(s));
    end
    ctrl.illegal = (ctrl.sizeSel == '0);
    ctrl.sub     = doSub;
    ctrl.rnd     = doRound;
    ctrl.upper   = upperHalf;
    ctrl.load    = inValid;
  end

endmodule

// File: rtl/nh_datapath.sv
module nh_datapath
  import nh_pkg::*;
#(
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  nhCtrl_t       ctrl,
  input  logic [VW-1:0] srcA,
  input  logic [VW-1:0] srcB,
  input  logic [VW-1:0] dstOld,
  output logic          outValid,
  output logic [VW-1:0] result,
  output logic          illegal
);

  localparam int HW = VW / 2;

  logic [HW-1:0] narrowBySize [NUM_SIZES];
  logic [HW-1:0] picked;
  logic [VW-1:0] nextVec;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : gSize
    localparam int NW    = BASE_NW << s;
    localparam int WW    = 2 * NW;
    localparam int LANES = HW / NW;
    localparam logic [WW-1:0] RND_K = WW'(1) << (NW - 1);

    logic [HW-1:0] lanesOut;

    for (genvar l = 0; l < LANES; l++) begin : gLane
      logic [WW-1:0] wideA, wideB, combined, rounded;
      assign wideA    = srcA[l*WW +: WW];
      assign wideB    = srcB[l*WW +: WW];
      assign combined = ctrl.sub ? (wideA - wideB) : (wideA + wideB);
      assign rounded  = combined + (ctrl.rnd ? RND_K : '0);
      assign lanesOut[l*NW +: NW] = rounded[WW-1 -: NW];
    end

    assign narrowBySize[s] = lanesOut;
  end

  always_comb begin
    picked = '0;
    for (int s = 0; s < NUM_SIZES; s++) begin
      if (ctrl.sizeSel[s]) picked = picked | narrowBySize[s];
    end
  end

  always_comb begin
    if (ctrl.illegal)    nextVec = dstOld;
    else if (ctrl.upper) nextVec = {picked, dstOld[HW-1:0]};
    else                 nextVec = {{HW{1'b0}}, picked};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      illegal  <= 1'b0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        result  <= nextVec;
        illegal <= ctrl.illegal;
      end
    end
  end

endmodule

// File: rtl/nh_unit.sv
module nh_unit
  import nh_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [VEC_W-1:0]   srcA,
  input  logic [VEC_W-1:0]   srcB,
  input  logic [VEC_W-1:0]   dstOld,
  input  logic [1:0]         sizeCode,
  input  logic               doSub,
  input  logic               doRound,
  input  logic               upperHalf,
  output logic               outValid,
  output logic [VEC_W-1:0]   result,
  output logic               illegal
);

  nhCtrl_t ctrl;

  nh_ctrl uCtrl (
    .inValid   (inValid),
    .sizeCode  (sizeCode),
    .doSub     (doSub),
    .doRound   (doRound),
    .upperHalf (upperHalf),
    .ctrl      (ctrl)
  );

  nh_datapath #(.VW(VEC_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .srcA     (srcA),
    .srcB     (srcB),
    .dstOld   (dstOld),
    .outValid (outValid),
    .result   (result),
    .illegal  (illegal)
  );

endmodule

// File: rtl/nh_checker.sv
module nh_checker (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [127:0] dstOld,
  input logic [1:0]   sizeCode,
  input logic         upperHalf,
  input logic         outValid,
  input logic [127:0] result,
  input logic         illegal
);

  assert_valid_timing_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(illegal)));

  assert_illegal_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (illegal == ($past(sizeCode) == 2'd3)));

  assert_illegal_passthru_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && illegal) |-> (result == $past(dstOld)));

  assert_low_place_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !illegal && !$past(upperHalf)) |-> (result[127:64] == 64'd0));

  assert_high_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !illegal && $past(upperHalf)) |-> (result[63:0] == $past(dstOld[63:0])));

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_clear_R9: assert (!outValid && !illegal && result == '0);
    end
  end

endmodule

bind nh_unit nh_checker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .dstOld    (dstOld),
  .sizeCode  (sizeCode),
  .upperHalf (upperHalf),
  .outValid  (outValid),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/nh_unit_test.sv
module nh_unit_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] srcA = '0, srcB = '0, dstOld = '0;
  logic [1:0]   sizeCode = '0;
  logic         doSub = 1'b0, doRound = 1'b0, upperHalf = 1'b0;
  logic         outValid, illegal;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nh_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .dstOld(dstOld), .sizeCode(sizeCode), .doSub(doSub), .doRound(doRound),
    .upperHalf(upperHalf), .outValid(outValid), .result(result), .illegal(illegal)
  );

  function automatic logic [127:0] refModel(
    input logic [127:0] a, input logic [127:0] b, input logic [127:0] old,
    input logic [1:0] sz, input logic sub, input logic rnd, input logic up);
    logic [63:0] packedV;
    logic [63:0] mask, wa, wb, acc;
    int nw, ww;
    if (sz == 2'd3) return old;
    nw = 8 << sz;
    ww = 2 * nw;
    mask = (ww == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ww) - 64'd1);
    packedV = '0;
    for (int l = 0; l < 64 / nw; l++) begin
      wa  = 64'(a >> (l * ww)) & mask;
      wb  = 64'(b >> (l * ww)) & mask;
      acc = (sub ? (wa - wb) : (wa + wb)) & mask;
      if (rnd) acc = (acc + (64'd1 << (nw - 1))) & mask;
      packedV = packedV | ((acc >> nw) << (l * nw));
    end
    if (up) return {packedV, old[63:0]};
    return {64'd0, packedV};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [127:0] a, input logic [127:0] b, input logic [127:0] old,
                       input logic [1:0] sz, input logic sub, input logic rnd, input logic up);
    logic [127:0] exp;
    logic [127:0] held;
    string tag;
    exp = refModel(a, b, old, sz, sub, rnd, up);
    if (sz == 2'd3)  tag = "R7";
    else if (rnd)    tag = "R3 R4";
    else if (sub)    tag = "R2 R4";
    else             tag = "R1 R4";
    @(negedge clk);
    srcA = a; srcB = b; dstOld = old; sizeCode = sz;
    doSub = sub; doRound = rnd; upperHalf = up; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    srcA = ~a; dstOld = ~old; sizeCode = 2'd3;
    check({tag, " result"}, result, exp);
    check("R7 illegal flag", {127'd0, illegal}, {127'd0, sz == 2'd3});
    check("R8 valid pulse", {127'd0, outValid}, 128'd1);
    if (sz != 2'd3) begin
      if (up) check("R6 low half kept", {64'd0, result[63:0]}, {64'd0, old[63:0]});
      else    check("R5 high half zero", {64'd0, result[127:64]}, 128'd0);
    end
    held = result;
    @(negedge clk);
    check("R8 hold result", result, held);
    check("R8 valid low", {127'd0, outValid}, 128'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] pa [6];
    logic [127:0] pb [6];
    logic [127:0] old;
    repeat (3) @(negedge clk);
    check("R9 reset result", result, 128'd0);
    check("R9 reset valid/illegal", {126'd0, outValid, illegal}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);

    pa[0] = {$urandom, $urandom, $urandom, $urandom};
    pb[0] = {$urandom, $urandom, $urandom, $urandom};
    pa[1] = {128{1'b1}};     pb[1] = '0;
    pa[2] = {16{8'h80}};     pb[2] = '0;
    pa[3] = {16{8'h7F}};     pb[3] = '0;
    pa[4] = '0;              pb[4] = {16{8'h01}};
    pa[5] = {$urandom, $urandom, $urandom, $urandom};
    pb[5] = pa[5] ^ {4{32'h0000_00FF}};

    for (int p = 0; p < 6; p++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int m = 0; m < 8; m++) begin
          old = {$urandom, $urandom, $urandom, $urandom};
          runOp(pa[p], pb[p], old, 2'(sz), m[0], m[1], m[2]);
        end
      end
    end

    for (int k = 0; k < 40; k++) begin
      runOp({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, 2'($urandom % 3),
            1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule